// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block keeps a free-running wide count that advances at a fixed nominal rate, 6.144 MHz in the intended system, whatever the frequency of its reference clock. The conversion is a rational one. On every reference edge a residue accumulator gains the programmed numerator. When the accumulator reaches the programmed denominator, the denominator is taken away and the count steps by one. The long-run count rate is therefore the reference rate times num/den. Software picks the ratio for the board's reference. Examples are 64/125 for 12 MHz, 768/1625 for 13 MHz, 8/25 for 19.2 MHz, 192/625 for 20 MHz, 384/1625 for 26 MHz, 256/1125 for 27 MHz and 4/25 for 38.4 MHz. When the reference is derived from the slow fallback oscillator, 75/244 applies. The rate quoted to software is the product rounded up.

A small word-wide register port reaches two 12-bit ratio fields and the two halves of the count. Reading the low half freezes a copy of the high half. A following read of the high half then pairs with that low half, even if a carry happened in between.

Top module: `rtc_frac_counter`

## Requirements
- R1: During and straight after reset the count is zero, the latched high half is zero, the numerator field holds 4 and the denominator field holds 25.
- R2: A write to offset 0x10 loads bits 11:0 of the data into the numerator field, and a write to offset 0x14 loads them into the denominator field. Reads of either offset return the field in bits 11:0, and bits 31:12 always read as zero whatever was written there.
- R3: With 1 <= num < den <= 4095, the count k reference edges after a ratio write equals its value just after that write plus floor(k*num/den).
- R4: The count changes by zero or one per reference edge, and the accumulator residue stays below den whenever the ratio is valid.
- R5: When den is zero or num >= den, the count advances by one on every reference edge.
- R6: The edge that takes a ratio write clears the accumulator residue. On that same edge the count still advances as decided by the settings in force before the write.
- R7: A read at offset 0x00 returns the low CNT_W/2 bits of the present count, zero-extended, and latches the high CNT_W/2 bits on that edge. A read at offset 0x04 returns the latched high bits.
- R8: Offsets other than 0x00, 0x04, 0x10 and 0x14 read as zero, and writes to them change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |

## Verification
The two functions that can meet in one cycle are the high-half latch of a low read and the carry out of the low half. The bench sets a ratio that steps the count every edge. It then issues low/high read pairs back to back in two phase-shifted passes, so that low reads land on and around the 0xFF-to-0x00 roll of an 8-bit half. Every reassembled value must equal the count predicted for the cycle of its low read. A second meeting is a ratio write against an accumulator carrying residue. That case is judged by comparing the count after the write with floor arithmetic that includes the write edge under the old settings and restarts from zero residue afterwards.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 5;
  localparam int FIELD_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_NUM    = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_DEN    = 5'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CNT_LO, SEL_CNT_HI, SEL_NUM, SEL_DEN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_CNT_LO: return SEL_CNT_LO;
      OFS_CNT_HI: return SEL_CNT_HI;
      OFS_NUM:    return SEL_NUM;
      OFS_DEN:    return SEL_DEN;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ratio_regs.sv
module rtc_ratio_regs #(
  parameter int FIELD_W = 12,
  parameter int RST_NUM = 4,
  parameter int RST_DEN = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_num_i,
  input  logic               wr_den_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [FIELD_W-1:0] num_o,
  output logic [FIELD_W-1:0] den_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_o <= FIELD_W'(RST_NUM);
      den_o <= FIELD_W'(RST_DEN);
    end else begin
      if (wr_num_i) num_o <= field_i;
      if (wr_den_i) den_o <= field_i;
    end
  end
endmodule

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum #(
  parameter int FIELD_W = 12,
  localparam int ACC_W  = FIELD_W + 1,
  localparam int SUM_W  = FIELD_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] num_i,
  input  logic [FIELD_W-1:0] den_i,
  input  logic               clr_i,
  output logic               tick_o,
  output logic [ACC_W-1:0]   acc_o
);
  logic [SUM_W-1:0] sum, den_x;
  logic [ACC_W-1:0] acc_nxt;
  logic             degen;

  assign den_x = SUM_W'(den_i);
  assign sum   = SUM_W'(acc_o) + SUM_W'(num_i);
  assign degen = (den_i == '0) || (num_i >= den_i);

  always_comb begin
    if (degen) begin
      tick_o  = 1'b1;
      acc_nxt = '0;
    end else if (sum >= den_x) begin
      tick_o  = 1'b1;
      acc_nxt = ACC_W'(sum - den_x);
    end else begin
      tick_o  = 1'b0;
      acc_nxt = ACC_W'(sum);
    end
  end

  // a ratio write restarts the phase; the tick of this edge still counts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else            acc_o <= acc_nxt;
  end
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int CNT_W   = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              latch_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [HALF_W-1:0] shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + CNT_W'(tick_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_o <= '0;
    else if (latch_i) shadow_o <= cnt_o[CNT_W-1:HALF_W];
  end
endmodule

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter
  import rtc_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int RST_NUM = 4,
  parameter int RST_DEN = 25,
  localparam int HALF_W = CNT_W / 2,
  localparam int ACC_W  = FIELD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o
);
  reg_sel_e           sel;
  logic               wr_num, wr_den, wr_hit, rd_lo, tick;
  logic [FIELD_W-1:0] num, den;
  logic [ACC_W-1:0]   acc;
  logic [CNT_W-1:0]   cnt;
  logic [HALF_W-1:0]  shadow;

  assign sel    = decode_ofs(addr_i);
  assign wr_num = req_i && we_i && (sel == SEL_NUM);
  assign wr_den = req_i && we_i && (sel == SEL_DEN);
  assign wr_hit = wr_num || wr_den;
  assign rd_lo  = req_i && !we_i && (sel == SEL_CNT_LO);

  rtc_ratio_regs #(.FIELD_W(FIELD_W), .RST_NUM(RST_NUM), .RST_DEN(RST_DEN)) u_regs (
    .clk_i, .rst_ni,
    .wr_num_i(wr_num), .wr_den_i(wr_den),
    .field_i (wdata_i[FIELD_W-1:0]),
    .num_o   (num), .den_o(den)
  );

  rtc_frac_accum #(.FIELD_W(FIELD_W)) u_accum (
    .clk_i, .rst_ni,
    .num_i(num), .den_i(den), .clr_i(wr_hit),
    .tick_o(tick), .acc_o(acc)
  );

  rtc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .tick_i(tick), .latch_i(rd_lo),
    .cnt_o(cnt), .shadow_o(shadow)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (sel)
        SEL_CNT_LO: rdata_o = BUS_W'(cnt[HALF_W-1:0]);
        SEL_CNT_HI: rdata_o = BUS_W'(shadow);
        SEL_NUM:    rdata_o = BUS_W'(num);
        SEL_DEN:    rdata_o = BUS_W'(den);
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_frac_counter_chk.sv
module rtc_frac_counter_chk
  import rtc_pkg::*;
#(
  parameter int CNT_W   = 64,
  localparam int HALF_W = CNT_W / 2,
  localparam int ACC_W  = FIELD_W + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [BUS_W-1:0]   rdata_o,
  input logic [CNT_W-1:0]   cnt,
  input logic [HALF_W-1:0]  shadow,
  input logic [ACC_W-1:0]   acc,
  input logic [FIELD_W-1:0] num,
  input logic [FIELD_W-1:0] den
);
  logic ratio_ok, wr_ratio, rd_low, rd_cfg;
  assign ratio_ok = (den != '0) && (num < den);
  assign wr_ratio = req_i && we_i && (addr_i == OFS_NUM || addr_i == OFS_DEN);
  assign rd_low   = req_i && !we_i && (addr_i == OFS_CNT_LO);
  assign rd_cfg   = req_i && !we_i && (addr_i == OFS_NUM || addr_i == OFS_DEN);

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)));

  assert_residue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_ok |-> (ACC_W'(den) > acc));

  assert_degen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ratio_ok |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ratio |=> (acc == '0));

  assert_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_low |=> (shadow == $past(cnt[CNT_W-1:HALF_W])));

  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cfg |-> (rdata_o[BUS_W-1:FIELD_W] == '0));
endmodule

bind rtc_frac_counter rtc_frac_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .cnt(cnt), .shadow(shadow), .acc(acc), .num(num), .den(den)
);

// File: tb/rtc_frac_counter_test.sv
module rtc_frac_counter_test;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;
  localparam int HALF  = CNT_W / 2;

  logic        clk = 0, rst_n = 0, req = 0, we = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  rtc_frac_counter #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 req = 0;
  endtask

  // ratio sweep: j counts edges since the ratio write
  task automatic sweep(input int n, input int d, input int len, input string r);
    logic [31:0] v;
    int c0;
    wr(5'h10, 32'(n)); wr(5'h14, 32'(d));
    rd(5'h00, v); c0 = int'(v);
    for (int j = 1; j < len; j++) begin
      int e;
      rd(5'h00, v);
      e = (d == 0 || n >= d) ? (c0 + j) & 8'hFF : (c0 + (j * n) / d) & 8'hFF;
      chk(v == 32'(e), r, v, e);
    end
  endtask

  // low/high pairs; a low read latches the high half in its own cycle
  task automatic pairs(input int np);
    logic [31:0] lo, hi;
    int full0;
    rd(5'h00, lo); rd(5'h04, hi);
    full0 = int'({hi[HALF-1:0], lo[HALF-1:0]});
    for (int p = 1; p < np; p++) begin
      int e;
      rd(5'h00, lo); rd(5'h04, hi);
      e = (full0 + 2 * p) & 16'hFFFF;
      chk({hi[HALF-1:0], lo[HALF-1:0]} == 16'(e), "R7 pair", {hi[HALF-1:0], lo[HALF-1:0]}, e);
      chk(hi[31:HALF] == '0 && lo[31:HALF] == '0, "R7 zero-ext", {hi, lo}, 0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c0;
    // R1 reset state, read while reset is held
    rd(5'h00, v); chk(v == 0, "R1 count", v, 0);
    rd(5'h04, v); chk(v == 0, "R1 high", v, 0);
    rd(5'h10, v); chk(v == 4, "R1 num", v, 4);
    rd(5'h14, v); chk(v == 25, "R1 den", v, 25);
    @(negedge clk); rst_n = 1;

    // R2 field placement, upper bits read zero
    wr(5'h10, 32'hFFFFF040); rd(5'h10, v); chk(v == 32'h40, "R2 num", v, 32'h40);
    wr(5'h14, 32'hABCDE07D); rd(5'h14, v); chk(v == 32'h7D, "R2 den", v, 32'h7D);

    // R8 unmapped offsets
    wr(5'h08, 32'hFFFFFFFF); wr(5'h1C, 32'h00000FFF);
    rd(5'h08, v); chk(v == 0, "R8 read zero", v, 0);
    rd(5'h1C, v); chk(v == 0, "R8 read zero", v, 0);
    rd(5'h10, v); chk(v == 32'h40, "R8 num kept", v, 32'h40);
    rd(5'h14, v); chk(v == 32'h7D, "R8 den kept", v, 32'h7D);

    // R3 all reference ratios
    sweep(64, 125, 300, "R3 12MHz");
    sweep(768, 1625, 300, "R3 13MHz");
    sweep(8, 25, 300, "R3 19.2MHz");
    sweep(192, 625, 300, "R3 20MHz");
    sweep(384, 1625, 300, "R3 26MHz");
    sweep(256, 1125, 300, "R3 27MHz");
    sweep(4, 25, 300, "R3 38.4MHz");
    sweep(75, 244, 300, "R3 fallback");
    sweep(4094, 4095, 200, "R3 near-one");
    sweep(1, 4095, 200, "R3 slowest");

    // R5 degenerate ratios
    sweep(30, 30, 40, "R5 num=den");
    sweep(5, 0, 40, "R5 den=0");
    sweep(100, 7, 40, "R5 num>den");

    // R6 residue cleared by a write; the write edge uses the old phase
    wr(5'h10, 32'd7); wr(5'h14, 32'd10);
    rd(5'h00, v); c0 = int'(v);
    for (int j = 1; j < 13; j++) begin
      int e;
      rd(5'h00, v); e = (c0 + (j * 7) / 10) & 8'hFF;
      chk(v == 32'(e), "R6 pre", v, e);
    end
    wr(5'h10, 32'd7);
    rd(5'h00, v);
    chk(v == 32'((c0 + 9) & 8'hFF), "R6 write edge", v, (c0 + 9) & 8'hFF);
    c0 = int'(v);
    for (int j = 1; j < 30; j++) begin
      int e;
      rd(5'h00, v); e = (c0 + (j * 7) / 10) & 8'hFF;
      chk(v == 32'(e), "R6 restart", v, e);
    end

    // R7 latch against carry, two phases
    wr(5'h10, 32'd1); wr(5'h14, 32'd1);
    pairs(300);
    @(posedge clk);
    pairs(300);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule